// File: doc/BRIEF.md
# Register Bus Target with Wait-State Handshake

This block is the target side of a synchronous register bus. Each clock the master presents an 8-bit address, 16-bit write data and four control strobes: init, address valid, read enable and write enable. The target answers with 16-bit read data and three status lines: acknowledge, busy and error. Inside the target sits a small bank of 16-bit registers. The bank lives in an address window that starts at a configurable base and spans a configurable number of locations.

The target decodes the cycle type from the four strobes taken together. The master raises address valid on its own for one cycle, then holds it together with read or write enable until the target lowers busy. The target can stretch each access by a configurable number of wait states. Read data is taken by the master in the cycle where busy is low. A write is stored in that same cycle.

The location at offset 0 of the window is a read-only status word, taken directly from an input port. A write to it is acknowledged and flagged as an error. An external init cycle that addresses the window clears every writable register. Internal init cycles belong to the master, and the target ignores them.

Top module: `regbus_target`

## Requirements
- R1: Only strobe patterns {init,aval,re,we} = 0110 (read) and 0101 (write) start an access. Address valid alone, read or write enable without address valid, and both enables high together all leave ack, busy, err and rdata at 0.
- R2: A read or write gets a response only when the address lies in [BASE_ADDR, BASE_ADDR+NUM_REGS). Outside that range, ack, busy, err and rdata stay 0, and a write changes no register.
- R3: During a read in the window, rdata carries the register at offset (addr - BASE_ADDR), and offset 0 returns status_in. rdata is 0 whenever no read in the window is in progress.
- R4: For an access in the window, busy is high during the first WAIT_STATES cycles in which read or write enable is held, and then goes low. ack stays high for the whole access.
- R5: A write to a writable offset stores wdata once, in the cycle where busy is low. A later read of that offset returns the value written.
- R6: A write to offset 0 finishes with ack and err both high in its final cycle and leaves the status word unchanged.
- R7: An external init pulse (pattern 1001) whose address lies in the window clears all writable registers to 0 at that clock edge.
- R8: An internal init pulse (pattern 1000) at any address, and an external init outside the window, change no register and produce no response.
- R9: After synchronous reset, all writable registers read 0 and ack, busy, err and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Init strobe |
| bus_aval | input | 1 | Address valid strobe |
| bus_re | input | 1 | Read enable strobe |
| bus_we | input | 1 | Write enable strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| status_in | input | 16 | Live value returned at window offset 0 |
| bus_rdata | output | 16 | Read data |
| bus_ack | output | 1 | Address acknowledged |
| bus_busy | output | 1 | Stretch current access |
| bus_err | output | 1 | Error on current access |

## Verification
The hardest case to reach is a write that must be stored exactly once even though the master holds the strobes high through several busy cycles. The bench checks this by replaying the whole access with a model that counts held cycles on its own. It then reads the value back. The ignored init flavours are hard to observe because they produce no response at all. The bench therefore fills registers with known values first, fires the init pulses (internal, and external outside the window), and reads every affected location back through ordinary bus reads.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_ADDR,
        CYC_READ,
        CYC_WRITE,
        CYC_INIT_INT,
        CYC_INIT_EXT,
        CYC_BAD
    } cyc_e;

    typedef struct packed {
        logic              ack;
        logic              busy;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    function automatic cyc_e decode_cyc(input logic init, input logic aval,
                                        input logic re, input logic we);
        cyc_e c;
        case ({init, aval, re, we})
            4'b0000: c = CYC_IDLE;
            4'b0100: c = CYC_ADDR;
            4'b0110: c = CYC_READ;
            4'b0101: c = CYC_WRITE;
            4'b1000: c = CYC_INIT_INT;
            4'b1001: c = CYC_INIT_EXT;
            default: c = CYC_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/regbus_decode.sv
module regbus_decode
    import regbus_pkg::*;
#(
    parameter int BASE_ADDR = 8'h40,
    parameter int NUM_REGS  = 8,
    localparam int OFF_W    = $clog2(NUM_REGS)
) (
    input  logic              init,
    input  logic              aval,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output cyc_e              cyc,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + NUM_REGS);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] delta;

    always_comb begin
        cyc    = decode_cyc(init, aval, re, we);
        addr_x = {1'b0, addr};
        delta  = addr_x - LO;
        hit    = (addr_x >= LO) && (addr_x < HI);
        off    = delta[OFF_W-1:0];
    end
endmodule

// File: rtl/regbus_waitgen.sv
module regbus_waitgen #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic busy
);
    generate
        if (WAIT_STATES == 0) begin : g_nowait
            assign busy = 1'b0;
        end else begin : g_wait
            localparam int CNT_W = $clog2(WAIT_STATES + 1);
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_STATES);
            logic [CNT_W-1:0] held;

            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= '0;
                end else if (!active) begin
                    held <= '0;
                end else if (held < LIMIT) begin
                    held <= held + 1'b1;
                end
            end

            assign busy = active && (held < LIMIT);
        end
    endgenerate
endmodule

// File: rtl/regbus_bank.sv
module regbus_bank
    import regbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int OFF_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            for (int i = 0; i < NUM_REGS; i++) store[i] <= '0;
        end else if (wr_en && (wr_off != '0)) begin
            store[wr_off] <= wr_data;
        end
    end

    always_comb begin
        if (rd_off == '0) rd_data = status_in;
        else              rd_data = store[rd_off];
    end
endmodule

// File: rtl/regbus_target.sv
module regbus_target
    import regbus_pkg::*;
#(
    parameter int BASE_ADDR   = 8'h40,
    parameter int NUM_REGS    = 8,
    parameter int WAIT_STATES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_init,
    input  logic        bus_aval,
    input  logic        bus_re,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic [15:0] status_in,
    output logic [15:0] bus_rdata,
    output logic        bus_ack,
    output logic        bus_busy,
    output logic        bus_err
);
    localparam int OFF_W = $clog2(NUM_REGS);

    cyc_e              cyc;
    logic              hit;
    logic [OFF_W-1:0]  off;
    logic              rd_hit, wr_hit, active, stall, ro_loc;
    logic [DATA_W-1:0] bank_q;
    resp_t             resp;

    regbus_decode #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_decode (
        .init(bus_init), .aval(bus_aval), .re(bus_re), .we(bus_we),
        .addr(bus_addr), .cyc(cyc), .hit(hit), .off(off)
    );

    assign rd_hit = (cyc == CYC_READ)  && hit;
    assign wr_hit = (cyc == CYC_WRITE) && hit;
    assign active = rd_hit || wr_hit;
    assign ro_loc = (off == '0);

    regbus_waitgen #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk(clk), .rst(rst), .active(active), .busy(stall)
    );

    regbus_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_hit && !stall && !ro_loc),
        .wr_off(off), .wr_data(bus_wdata),
        .clr_all((cyc == CYC_INIT_EXT) && hit),
        .rd_off(off), .status_in(status_in), .rd_data(bank_q)
    );

    always_comb begin
        resp.ack   = active;
        resp.busy  = stall;
        resp.err   = wr_hit && ro_loc;
        resp.rdata = rd_hit ? bank_q : '0;
    end

    assign bus_ack   = resp.ack;
    assign bus_busy  = resp.busy;
    assign bus_err   = resp.err;
    assign bus_rdata = resp.rdata;
endmodule

module regbus_target_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_init,
    input logic        bus_aval,
    input logic        bus_re,
    input logic        bus_we,
    input logic [15:0] bus_rdata,
    input logic        bus_ack,
    input logic        bus_busy,
    input logic        bus_err
);
    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst) run <= 0;
        else     run <= bus_busy ? run + 1 : 0;
    end

    AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> (run < WAIT_STATES)); // R4
    AST_BUSY_HAS_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> bus_ack); // R4
    AST_ERR_HAS_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_ack && bus_we)); // R6
    AST_NO_AVAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_aval |-> (!bus_ack && !bus_busy && !bus_err && bus_rdata == '0)); // R1
    AST_RDATA_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> (bus_rdata == '0)); // R3
    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_init |-> !bus_ack); // R8
endmodule

bind regbus_target regbus_target_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk(clk), .rst(rst), .bus_init(bus_init), .bus_aval(bus_aval),
    .bus_re(bus_re), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_busy(bus_busy), .bus_err(bus_err)
);

// File: tb/test_regbus_target.sv
module test_regbus_target;
    localparam int CLK_PERIOD = 10;
    localparam int BASE  = 8'h40;
    localparam int NREG  = 8;
    localparam int NWAIT = 2;

    logic clk = 0, rst = 1;
    logic init = 0, aval = 0, re = 0, we = 0;
    logic [7:0]  addr = 0;
    logic [15:0] wdata = 0, stat = 16'h5A5A;
    logic [15:0] rdata;
    logic ack, busy, err;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] mreg [NREG];
    int mw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_target #(.BASE_ADDR(BASE), .NUM_REGS(NREG), .WAIT_STATES(NWAIT)) i_regbus_target (
        .clk(clk), .rst(rst), .bus_init(init), .bus_aval(aval), .bus_re(re),
        .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .status_in(stat),
        .bus_rdata(rdata), .bus_ack(ack), .bus_busy(busy), .bus_err(err)
    );

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input logic [7:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + NREG);
    endfunction

    // reference model: state update on each rising edge
    always @(posedge clk) begin
        bit drd, dwr, h;
        int o;
        drd = !init && aval && re && !we;
        dwr = !init && aval && !re && we;
        h = in_win(addr);
        o = int'(addr) - BASE;
        if (rst) begin
            for (int i = 0; i < NREG; i++) mreg[i] = 0;
            mw = 0;
        end else begin
            if (dwr && h && mw >= NWAIT && o != 0) mreg[o] = wdata;
            if (init && !aval && !re && we && h)
                for (int i = 0; i < NREG; i++) mreg[i] = 0;
            if ((drd || dwr) && h) begin
                if (mw < NWAIT) mw++;
            end else mw = 0;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        bit drd, dwr, h, eb, ea, ee;
        int o;
        logic [15:0] ed;
        string tag;
        if (!rst) begin
            drd = !init && aval && re && !we;
            dwr = !init && aval && !re && we;
            h = in_win(addr);
            o = int'(addr) - BASE;
            ea = (drd || dwr) && h;
            eb = ea && (mw < NWAIT);
            ee = dwr && h && o == 0;
            ed = (drd && h) ? ((o == 0) ? stat : mreg[o]) : 16'h0;
            if (init)            tag = "R8";
            else if (!drd && !dwr) tag = "R1";
            else if (!h)         tag = "R2";
            else if (eb)         tag = "R4";
            else if (ee)         tag = "R6";
            else if (drd)        tag = "R3";
            else                 tag = "R5";
            check(tag, {ack, busy, err, rdata}, {ea, eb, ee, ed});
        end
    end

    task automatic bus_cycle(input logic [7:0] a, input bit wr, input logic [15:0] d,
                             output logic [15:0] q);
        @(posedge clk); #1;
        addr = a; wdata = d; aval = 1;
        @(posedge clk); #1;
        if (wr) we = 1; else re = 1;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        q = rdata;
        @(posedge clk); #1;
        aval = 0; re = 0; we = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        logic [15:0] q;
        bus_cycle(a, 1, d, q);
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] q;
        bus_cycle(a, 0, 16'h0, q);
        check(tag, {3'b000, q}, {3'b000, exp});
    endtask

    task automatic raw(input logic [3:0] s, input logic [7:0] a, input int cycles);
        @(posedge clk); #1;
        {init, aval, re, we} = s; addr = a;
        repeat (cycles) @(posedge clk);
        #1 {init, aval, re, we} = 4'b0000;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R9", {ack, busy, err, rdata}, 19'h0);
        rd_expect(8'h43, 16'h0000, "R9");

        wr(8'h41, 16'h1234);
        wr(8'h42, 16'hABCD);
        wr(8'h47, 16'hFFFF);
        rd_expect(8'h41, 16'h1234, "R5");
        rd_expect(8'h42, 16'hABCD, "R5");
        rd_expect(8'h47, 16'hFFFF, "R3");
        rd_expect(8'h40, 16'h5A5A, "R3");
        stat = 16'hC3C3;
        rd_expect(8'h40, 16'hC3C3, "R3");

        wr(8'h40, 16'h0BAD);
        rd_expect(8'h40, 16'hC3C3, "R6");

        wr(8'h48, 16'h9999);
        wr(8'h3F, 16'h8888);
        rd_expect(8'h48, 16'h0000, "R2");
        rd_expect(8'h47, 16'hFFFF, "R2");

        raw(4'b0010, 8'h41, 3);
        raw(4'b0001, 8'h42, 3);
        raw(4'b0100, 8'h41, 4);
        raw(4'b0111, 8'h42, 3);
        rd_expect(8'h42, 16'hABCD, "R1");

        raw(4'b1000, 8'h41, 1);
        raw(4'b1000, 8'hF8, 1);
        raw(4'b1001, 8'h50, 1);
        rd_expect(8'h41, 16'h1234, "R8");
        rd_expect(8'h47, 16'hFFFF, "R8");

        raw(4'b1001, 8'h40, 1);
        rd_expect(8'h41, 16'h0000, "R7");
        rd_expect(8'h42, 16'h0000, "R7");
        rd_expect(8'h47, 16'h0000, "R7");

        wr(8'h45, 16'h5555);
        rd_expect(8'h45, 16'h5555, "R5");

        repeat (2) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule